// File: doc/BRIEF.md
# CPU Power Mode Clock Controller

This block holds a 16-bit operating-mode register on a simple 32-bit register bus and turns its contents into three enables: one for the main oscillator, one for the CPU clock and one for the peripheral clock. Software writes a request flag to move the system out of normal running into one of three low-power states. In halt, only the CPU clock is held. In sleep, both the CPU and peripheral clocks are held. In stop, the oscillator is switched off as well.

An enabled interrupt arrives on the wake input. It clears every request flag, which returns the block to normal running. When the oscillator is restarted after stop, the CPU and peripheral clock enables stay low for a parameterised number of stabilisation cycles. All three enables come from flops, so the downstream gating models only ever see changes on a clock edge.

The register decodes only a halfword write on the low two byte lanes at its own address. Any narrower or wider write is dropped.

Top module: `pmc_top`

## Requirements
- R1: After reset the mode register reads 0, and osc_en_o, cpu_clk_en_o and per_clk_en_o are all 1 (normal running).
- R2: Register bits: bit 0 and bit 1 are two oscillation-control bits, stored and read back. Bit 2 is the sleep request, bit 3 the halt request and bit 4 the stop request. Bits 31..5 of bus_rdata_o always read 0, and writes to them are ignored.
- R3: A write updates the register only when bus_addr_i equals REG_ADDR and bus_strb_i is exactly 4'b0011 (one halfword on lanes 0 and 1). Any other strobe pattern or address leaves the register unchanged.
- R4: With only the halt flag set, the outputs settle to oscillator 1, CPU clock 0 and peripheral clock 1.
- R5: With the sleep flag set and the stop flag clear, the outputs settle to oscillator 1, CPU clock 0 and peripheral clock 0.
- R6: With the stop flag set, all three enables are 0 one cycle after the register holds the flag.
- R7: When several flags are set, stop wins over sleep and sleep wins over halt. The register still reads back every written flag.
- R8: wake_i high at a clock edge clears bits 4..2 and keeps bits 1..0. It wins over a write in the same cycle, which is then dropped.
- R9: On leaving stop, osc_en_o rises one cycle after the flags clear. cpu_clk_en_o and per_clk_en_o rise exactly STAB_CYCLES cycles after osc_en_o. cpu_clk_en_o is never 1 while osc_en_o is 0.
- R10: The enables change exactly one clock edge after the register changes. They never change in the same cycle as the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wr_i | input | 1 | Write enable |
| bus_strb_i | input | DATA_W/8 | Byte-lane strobes of the write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data: the register at REG_ADDR, 0 elsewhere |
| wake_i | input | 1 | Enabled interrupt; returns the block to normal running |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |

## Verification
The mode function is driven with single-flag writes for halt, sleep and stop, and with the combined patterns stop+sleep+halt and sleep+halt. The single-flag writes show that each state has its own enable triple. The combined patterns show that the priority order is applied and not a bitwise merge. Writes with byte, word and upper-halfword strobes, and a halfword to a wrong address, show that only the one legal access shape reaches the register. Wake is applied after halt and after sleep, where the clocks return on the next cycle, and after stop, where the cycle-exact stabilisation delay is measured. A wake coinciding with a write shows which of the two wins.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

  // Field positions inside the mode register
  localparam int BIT_OSC0  = 0;
  localparam int BIT_OSC1  = 1;
  localparam int BIT_SLEEP = 2;
  localparam int BIT_HALT  = 3;
  localparam int BIT_STOP  = 4;
  localparam int REG_BITS  = 5;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_HALT  = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_STOP  = 2'd3
  } pm_mode_e;

  typedef struct packed {
    logic osc;
    logic cpu;
    logic per;
  } clk_en_t;

  // Enable triple wanted by each operating mode
  function automatic clk_en_t mode_targets(pm_mode_e m);
    clk_en_t t;
    case (m)
      MODE_HALT:  t = '{osc: 1'b1, cpu: 1'b0, per: 1'b1};
      MODE_SLEEP: t = '{osc: 1'b1, cpu: 1'b0, per: 1'b0};
      MODE_STOP:  t = '{osc: 1'b0, cpu: 1'b0, per: 1'b0};
      default:    t = '{osc: 1'b1, cpu: 1'b1, per: 1'b1};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pmc_regif.sv
`timescale 1ns/1ps
module pmc_regif
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h040
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic [DATA_W/8-1:0]   strb_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  wake_i,
  output logic [REG_BITS-1:0]   reg_o,
  output logic [DATA_W-1:0]     rdata_o
);

  localparam int NB = DATA_W / 8;
  localparam logic [NB-1:0] HALF_STRB = NB'(2'b11);

  logic [REG_BITS-1:0] mode_q;
  logic                hit;
  logic                legal_wr;
  logic [DATA_W-1:REG_BITS] unused_wdata;

  assign unused_wdata = wdata_i[DATA_W-1:REG_BITS];
  assign hit      = (addr_i == REG_ADDR);
  assign legal_wr = wr_i && hit && (strb_i == HALF_STRB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wake_i) begin
      mode_q[BIT_STOP:BIT_SLEEP] <= '0;
    end else if (legal_wr) begin
      mode_q <= wdata_i[REG_BITS-1:0];
    end
  end

  assign reg_o   = mode_q;
  assign rdata_o = hit ? DATA_W'(mode_q) : '0;

endmodule

// File: rtl/pmc_mode_dec.sv
`timescale 1ns/1ps
module pmc_mode_dec
  import pmc_pkg::*;
(
  input  logic [REG_BITS-1:0] reg_i,
  output pm_mode_e            mode_o
);

  always_comb begin
    if (reg_i[BIT_STOP])       mode_o = MODE_STOP;
    else if (reg_i[BIT_SLEEP]) mode_o = MODE_SLEEP;
    else if (reg_i[BIT_HALT])  mode_o = MODE_HALT;
    else                       mode_o = MODE_RUN;
  end

endmodule

// File: rtl/pmc_clk_seq.sv
`timescale 1ns/1ps
module pmc_clk_seq
  import pmc_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pm_mode_e mode_i,
  output logic     osc_en_o,
  output logic     cpu_en_o,
  output logic     per_en_o,
  output logic     busy_o
);

  localparam int CW = (STAB_CYCLES < 1) ? 1 : $clog2(STAB_CYCLES + 1);

  clk_en_t       tgt;
  logic          osc_q, cpu_q, per_q;
  logic [CW-1:0] cnt_q;

  assign tgt = mode_targets(mode_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q <= 1'b1;
      cpu_q <= 1'b1;
      per_q <= 1'b1;
      cnt_q <= '0;
    end else if (!tgt.osc) begin
      osc_q <= 1'b0;
      cpu_q <= 1'b0;
      per_q <= 1'b0;
      cnt_q <= '0;
    end else if (!osc_q) begin
      osc_q <= 1'b1;
      if (STAB_CYCLES == 0) begin
        cpu_q <= tgt.cpu;
        per_q <= tgt.per;
      end else begin
        cpu_q <= 1'b0;
        per_q <= 1'b0;
        cnt_q <= CW'(STAB_CYCLES);
      end
    end else if (cnt_q > CW'(1)) begin
      cnt_q <= cnt_q - CW'(1);
    end else begin
      cnt_q <= '0;
      cpu_q <= tgt.cpu;
      per_q <= tgt.per;
    end
  end

  assign osc_en_o = osc_q;
  assign cpu_en_o = cpu_q;
  assign per_en_o = per_q;
  assign busy_o   = (cnt_q != '0);

endmodule

// File: rtl/pmc_top.sv
`timescale 1ns/1ps
module pmc_top
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h040,
  parameter int STAB_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic [DATA_W/8-1:0] bus_strb_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic                wake_i,
  output logic                osc_en_o,
  output logic                cpu_clk_en_o,
  output logic                per_clk_en_o
);

  logic [REG_BITS-1:0] mode_reg;
  pm_mode_e            mode;
  logic                stab_busy;

  pmc_regif #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
  ) u_regif (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (bus_addr_i),
    .wr_i   (bus_wr_i),
    .strb_i (bus_strb_i),
    .wdata_i(bus_wdata_i),
    .wake_i (wake_i),
    .reg_o  (mode_reg),
    .rdata_o(bus_rdata_o)
  );

  pmc_mode_dec u_dec (
    .reg_i (mode_reg),
    .mode_o(mode)
  );

  pmc_clk_seq #(
    .STAB_CYCLES(STAB_CYCLES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode),
    .osc_en_o(osc_en_o),
    .cpu_en_o(cpu_clk_en_o),
    .per_en_o(per_clk_en_o),
    .busy_o  (stab_busy)
  );

endmodule

// File: rtl/pmc_chk.sv
`timescale 1ns/1ps
module pmc_chk
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h040,
  parameter int STAB_CYCLES = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic                bus_wr_i,
  input logic [DATA_W/8-1:0] bus_strb_i,
  input logic [DATA_W-1:0]   bus_rdata_o,
  input logic                wake_i,
  input logic                osc_en_o,
  input logic                cpu_clk_en_o,
  input logic                per_clk_en_o,
  input logic [REG_BITS-1:0] mode_reg,
  input logic                stab_busy
);

  localparam logic [DATA_W/8-1:0] HALF = (DATA_W/8)'(2'b11);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[DATA_W-1:REG_BITS] == '0);

  assert_bad_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_strb_i != HALF && !wake_i) |=> $stable(mode_reg));

  assert_bad_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i != REG_ADDR && !wake_i) |=> $stable(mode_reg));

  assert_halt_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_reg[BIT_HALT] && !mode_reg[BIT_SLEEP] && !mode_reg[BIT_STOP]
     && osc_en_o && !stab_busy) |=> (osc_en_o && !cpu_clk_en_o && per_clk_en_o));

  assert_stop_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reg[BIT_STOP] |=> (!osc_en_o && !cpu_clk_en_o && !per_clk_en_o));

  assert_wake_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> (mode_reg[BIT_STOP:BIT_SLEEP] == '0));

  assert_cpu_needs_osc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en_o |-> osc_en_o);

  generate
    if (STAB_CYCLES > 0) begin : g_stab
      assert_stab_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en_o) |-> (!cpu_clk_en_o && !per_clk_en_o));
    end
  endgenerate

endmodule

bind pmc_top pmc_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .STAB_CYCLES(STAB_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_strb_i(bus_strb_i), .bus_rdata_o(bus_rdata_o), .wake_i(wake_i),
  .osc_en_o(osc_en_o), .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
  .mode_reg(mode_reg), .stab_busy(stab_busy)
);

// File: tb/pmc_top_tb.sv
`timescale 1ns/1ps
module pmc_top_tb;

  localparam int STAB = 6;
  localparam logic [11:0] RA = 12'h040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = RA;
  logic        wr = 1'b0;
  logic [3:0]  strb = 4'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake = 1'b0;
  logic        osc, cpu, per;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pmc_top #(.STAB_CYCLES(STAB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_strb_i(strb), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .wake_i(wake), .osc_en_o(osc), .cpu_clk_en_o(cpu), .per_clk_en_o(per)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [3:0] s, input logic [31:0] d);
    addr = a; strb = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; strb = 4'b0; addr = RA;
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  task automatic read_reg(output logic [31:0] v);
    addr = RA; #1; v = rdata;
  endtask

  task automatic chk_en(input string tag, input logic [2:0] exp);
    chk(tag, {29'b0, osc, cpu, per}, {29'b0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    read_reg(v);
    chk("R1 reset register", v, 32'h0);
    chk_en("R1 reset enables", 3'b111);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    bus_write(RA, 4'b0011, 32'hFFFF_FFE3);
    read_reg(v);
    chk("R2 readback masks reserved", v, 32'h0000_0003);
    step(1);
    chk_en("R2 osc bits leave clocks on", 3'b111);
  endtask

  task automatic t_access();
    logic [31:0] v;
    bus_write(RA, 4'b0001, 32'h0000_0008);
    bus_write(RA, 4'b1111, 32'h0000_0008);
    bus_write(RA, 4'b1100, 32'h0008_0008);
    bus_write(RA + 12'h4, 4'b0011, 32'h0000_0008);
    read_reg(v);
    chk("R3 illegal accesses ignored", v, 32'h0000_0003);
    step(1);
    chk_en("R3 clocks unchanged", 3'b111);
    addr = RA + 12'h4; #1;
    chk("R3 other address reads 0", rdata, 32'h0);
    addr = RA;
  endtask

  task automatic t_halt();
    logic [31:0] v;
    bus_write(RA, 4'b0011, 32'h0000_0008);
    chk_en("R10 no change in write cycle", 3'b111);
    step(1);
    chk_en("R4 halt enables", 3'b101);
    pulse_wake();
    read_reg(v);
    chk("R8 wake clears halt flag", v, 32'h0);
    step(1);
    chk_en("R8 halt exit", 3'b111);
  endtask

  task automatic t_sleep();
    bus_write(RA, 4'b0011, 32'h0000_0004);
    step(1);
    chk_en("R5 sleep enables", 3'b100);
    pulse_wake();
    step(1);
    chk_en("R8 sleep exit", 3'b111);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    bus_write(RA, 4'b0011, 32'h0000_001C);
    read_reg(v);
    chk("R7 all flags read back", v, 32'h0000_001C);
    step(1);
    chk_en("R7 stop wins", 3'b000);
    pulse_wake();
    step(STAB + 2);
    bus_write(RA, 4'b0011, 32'h0000_000C);
    step(1);
    chk_en("R7 sleep wins over halt", 3'b100);
    pulse_wake();
    step(1);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    bus_write(RA, 4'b0011, 32'h0000_0013);
    step(1);
    chk_en("R6 stop enables", 3'b000);
    pulse_wake();
    read_reg(v);
    chk("R8 wake keeps osc bits", v, 32'h0000_0003);
    step(1);
    chk_en("R9 oscillator restarts first", 3'b100);
    step(STAB - 1);
    chk_en("R9 still stabilising", 3'b100);
    step(1);
    chk_en("R9 clocks released", 3'b111);
  endtask

  task automatic t_wake_vs_write();
    logic [31:0] v;
    wake = 1'b1;
    bus_write(RA, 4'b0011, 32'h0000_0008);
    wake = 1'b0;
    read_reg(v);
    chk("R8 wake beats write", v, 32'h0000_0003);
    step(1);
    chk_en("R8 stays running", 3'b111);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_readback();
    t_access();
    t_halt();
    t_sleep();
    t_priority();
    t_stop();
    t_wake_vs_write();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule